// File: doc/BRIEF.md
# Timed flash self-programming control register

This block is an 8-bit control and status register that a CPU uses to start flash self-programming operations. A CPU write with the enable bit set arms one command: buffer fill, page write, page erase or configuration-bit read. The armed command lives for a short window of clock cycles. The command is issued only if the matching instruction strobe arrives inside that window. A store-program strobe consumes fill, write and erase. A load-program strobe consumes the configuration read. If no matching strobe arrives, the register disarms itself and issues nothing.

A page write or page erase keeps the enable bit set for as long as the external flash-busy input stays high. A ready interrupt is requested once the enable bit clears, provided the interrupt-enable bit and the global interrupt flag are both set and no EEPROM write is in progress. The flash array, the page-buffer storage and the erase/write timing are outside this block. The flash-busy input stands in for them.

Register bit positions: bit 7 interrupt enable, bit 6 and bit 5 read-only zero, bit 4 buffer-clear request, bit 3 configuration read, bit 2 page write, bit 1 page erase, bit 0 enable.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset, `regRdData` reads 0x00, every command output is low and `readyIrq` is low.
- R2: Bits 6 and 5 of `regRdData` always read zero. Bit 4 also always reads zero, because a buffer-clear request never stays armed.
- R3: A write of 0x05 (bits 2 and 0 set in bits 4:0) arms a page write, and `regRdData` shows bits 2 and 0 set. If `storeStrobe` is sampled on any of the 4 clock edges after the write edge, `cmdPageWrite` pulses for one cycle after that edge. At the same time `cmdPageAddr` equals `zPtr[ZW-1:PAGE_LSB]`.
- R4: A write of 0x03 arms a page erase. It uses the same 4-edge window and the same store strobe, and it produces a one-cycle `cmdPageErase` pulse with the page address taken from the upper Z bits.
- R5: A write of 0x09 arms a configuration read. If `loadStrobe` is sampled on any of the 3 edges after the write edge, `cmdCfgRead` pulses for one cycle. At the same time `cmdCfgSel` equals `zPtr[0]`: 1 selects the fuse bits and 0 selects the lock bits.
- R6: If the window ends without the matching strobe, bits 3:0 read zero from the last window edge onward, and no command is issued. A strobe of the other kind does not fire the armed command.
- R7: A write with bit 0 set and more than one of bits 4:1 set arms nothing. Bits 4:0 then read zero.
- R8: A write of 0x01 arms a buffer fill. A store strobe on one of the 4 edges after it pulses `cmdBufFill` and marks the buffer as holding data. A page write or a buffer clear marks the buffer empty again.
- R9: A write of 0x11 pulses `cmdBufClear` for one cycle if the buffer holds data. If the buffer is empty, the same write has no effect.
- R10: After a page write or page erase fires, bit 0 stays set for at least one cycle after the command pulse, and for as long as `flashBusy` is high. Bit 0 clears on the first edge after that on which `flashBusy` is sampled low.
- R11: `readyIrq` equals bit 7 AND `globalIntEn` AND NOT bit 0 AND NOT `eeBusy`.
- R12: While a command is armed or an operation is running, a register write changes only bit 7. A write with bit 0 clear arms nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | CPU register write strobe |
| regWrData | input | 8 | CPU write data |
| regRdData | output | 8 | Register readback |
| storeStrobe | input | 1 | Store-program instruction executed |
| loadStrobe | input | 1 | Load-program-memory instruction executed |
| zPtr | input | ZW | Z-pointer value |
| eeBusy | input | 1 | EEPROM write in progress |
| flashBusy | input | 1 | Flash erase/write in progress |
| globalIntEn | input | 1 | Global interrupt flag |
| cmdPageWrite | output | 1 | Page write command pulse |
| cmdPageErase | output | 1 | Page erase command pulse |
| cmdPageAddr | output | ZW-PAGE_LSB | Page address for write or erase |
| cmdBufFill | output | 1 | Buffer fill command pulse |
| cmdBufClear | output | 1 | Buffer clear command pulse |
| cmdCfgRead | output | 1 | Configuration-bit read pulse |
| cmdCfgSel | output | 1 | 1 selects fuse bits, 0 selects lock bits |
| readyIrq | output | 1 | Ready interrupt request |

## Verification
The bench drives a matching strobe on the last edge of each window and then on the first edge after it. A design with an off-by-one window count either drops a legal command or fires a stale one. It also drives the wrong strobe kind while a command is armed, which exposes a design that fires on any strobe. It writes several command bits at once, and it writes the clear request both with and without buffered data, so a design that arms on a mixed write, or clears an empty buffer, emits a stray pulse. It holds flash-busy for several cycles after a page operation: a design that drops the enable bit early raises the ready interrupt during the operation.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_WRITE, ST_ERASE, ST_CFG, ST_OP
  } armState_t;

  typedef struct packed {
    logic fireWrite;
    logic fireErase;
    logic fireFill;
    logic fireCfg;
    logic clearBuf;
  } fireStrobes_t;
endpackage

// File: rtl/fpc_control.sv
module fpc_control
  import fpc_pkg::*;
#(
  parameter int WRITE_WIN = 4,
  parameter int CFG_WIN   = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [4:0]   wrCmd,
  input  logic         storeStrobe,
  input  logic         loadStrobe,
  input  logic         flashBusy,
  input  logic         fillPending,
  output fireStrobes_t fire,
  output logic         selfEn,
  output logic [2:0]   armView
);
  localparam int MAXWIN = (WRITE_WIN > CFG_WIN) ? WRITE_WIN : CFG_WIN;
  localparam int CW     = $clog2(MAXWIN + 1);

  armState_t state, stateNxt;
  logic [CW-1:0] cnt, cntNxt;
  logic opFresh;
  logic accept;
  logic [2:0] nCmd;

  assign accept = regWrEn && wrCmd[0] && (state == ST_IDLE);
  assign nCmd   = 3'($countones(wrCmd[4:1]));

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    fire     = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          if (nCmd == 3'd0) begin
            stateNxt = ST_FILL;
            cntNxt   = CW'(WRITE_WIN);
          end else if (nCmd == 3'd1) begin
            if (wrCmd[2]) begin
              stateNxt = ST_WRITE;
              cntNxt   = CW'(WRITE_WIN);
            end else if (wrCmd[1]) begin
              stateNxt = ST_ERASE;
              cntNxt   = CW'(WRITE_WIN);
            end else if (wrCmd[3]) begin
              stateNxt = ST_CFG;
              cntNxt   = CW'(CFG_WIN);
            end else begin
              fire.clearBuf = fillPending;
            end
          end
        end
      end
      ST_FILL, ST_WRITE, ST_ERASE: begin
        if (storeStrobe) begin
          fire.fireFill  = (state == ST_FILL);
          fire.fireWrite = (state == ST_WRITE);
          fire.fireErase = (state == ST_ERASE);
          stateNxt = (state == ST_FILL) ? ST_IDLE : ST_OP;
        end else if (cnt == CW'(1)) begin
          stateNxt = ST_IDLE;
        end else begin
          cntNxt = cnt - CW'(1);
        end
      end
      ST_CFG: begin
        if (loadStrobe) begin
          fire.fireCfg = 1'b1;
          stateNxt = ST_IDLE;
        end else if (cnt == CW'(1)) begin
          stateNxt = ST_IDLE;
        end else begin
          cntNxt = cnt - CW'(1);
        end
      end
      ST_OP: begin
        if (!opFresh && !flashBusy) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      opFresh <= 1'b0;
    end else begin
      state   <= stateNxt;
      cnt     <= cntNxt;
      opFresh <= (stateNxt == ST_OP) && (state != ST_OP);
    end
  end

  assign selfEn  = (state != ST_IDLE);
  assign armView = {state == ST_CFG, state == ST_WRITE, state == ST_ERASE};

  // R6
  window_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {ST_FILL, ST_WRITE, ST_ERASE} && cnt == CW'(1) && !storeStrobe)
      |=> (state == ST_IDLE));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OP && flashBusy) |=> selfEn);

  // R12
  armed_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE && regWrEn && !storeStrobe && cnt != CW'(1))
      |=> (state == ST_WRITE));
endmodule

// File: rtl/fpc_datapath.sv
module fpc_datapath
  import fpc_pkg::*;
#(
  parameter int ZW       = 16,
  parameter int PAGE_LSB = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               wrIe,
  input  fireStrobes_t       fire,
  input  logic               selfEn,
  input  logic [2:0]         armView,
  input  logic [ZW-1:0]      zPtr,
  input  logic               eeBusy,
  input  logic               globalIntEn,
  output logic [7:0]         regRdData,
  output logic               cmdPageWrite,
  output logic               cmdPageErase,
  output logic [ZW-PAGE_LSB-1:0] cmdPageAddr,
  output logic               cmdBufFill,
  output logic               cmdBufClear,
  output logic               cmdCfgRead,
  output logic               cmdCfgSel,
  output logic               readyIrq,
  output logic               fillPending
);
  localparam int PAW = ZW - PAGE_LSB;

  logic ieBit;
  logic unusedZBits;
  assign unusedZBits = ^zPtr[PAGE_LSB-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieBit        <= 1'b0;
      fillPending  <= 1'b0;
      cmdPageWrite <= 1'b0;
      cmdPageErase <= 1'b0;
      cmdBufFill   <= 1'b0;
      cmdBufClear  <= 1'b0;
      cmdCfgRead   <= 1'b0;
      cmdCfgSel    <= 1'b0;
      cmdPageAddr  <= '0;
    end else begin
      if (regWrEn) ieBit <= wrIe;
      if (fire.fireFill) fillPending <= 1'b1;
      else if (fire.fireWrite || fire.clearBuf) fillPending <= 1'b0;
      cmdPageWrite <= fire.fireWrite;
      cmdPageErase <= fire.fireErase;
      cmdBufFill   <= fire.fireFill;
      cmdBufClear  <= fire.clearBuf;
      cmdCfgRead   <= fire.fireCfg;
      if (fire.fireCfg) cmdCfgSel <= zPtr[0];
      if (fire.fireWrite || fire.fireErase) cmdPageAddr <= zPtr[ZW-1 -: PAW];
    end
  end

  assign regRdData = {ieBit, 3'b000, armView, selfEn};
  assign readyIrq  = ieBit && globalIntEn && !selfEn && !eeBusy;

  // R10
  write_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdPageWrite || cmdPageErase) |-> selfEn);

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdBufClear |-> !fillPending);

  // R8
  fill_marks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdBufFill |-> fillPending);
endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import fpc_pkg::*;
#(
  parameter int ZW        = 16,
  parameter int PAGE_LSB  = 6,
  parameter int WRITE_WIN = 4,
  parameter int CFG_WIN   = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [7:0]             regWrData,
  output logic [7:0]             regRdData,
  input  logic                   storeStrobe,
  input  logic                   loadStrobe,
  input  logic [ZW-1:0]          zPtr,
  input  logic                   eeBusy,
  input  logic                   flashBusy,
  input  logic                   globalIntEn,
  output logic                   cmdPageWrite,
  output logic                   cmdPageErase,
  output logic [ZW-PAGE_LSB-1:0] cmdPageAddr,
  output logic                   cmdBufFill,
  output logic                   cmdBufClear,
  output logic                   cmdCfgRead,
  output logic                   cmdCfgSel,
  output logic                   readyIrq
);
  fireStrobes_t fire;
  logic selfEn;
  logic fillPending;
  logic [2:0] armView;
  logic unusedWrBits;
  assign unusedWrBits = ^regWrData[6:5];

  fpc_control #(.WRITE_WIN(WRITE_WIN), .CFG_WIN(CFG_WIN)) uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .wrCmd(regWrData[4:0]),
    .storeStrobe(storeStrobe), .loadStrobe(loadStrobe), .flashBusy(flashBusy),
    .fillPending(fillPending), .fire(fire), .selfEn(selfEn), .armView(armView)
  );

  fpc_datapath #(.ZW(ZW), .PAGE_LSB(PAGE_LSB)) uDp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .wrIe(regWrData[7]),
    .fire(fire), .selfEn(selfEn), .armView(armView), .zPtr(zPtr),
    .eeBusy(eeBusy), .globalIntEn(globalIntEn), .regRdData(regRdData),
    .cmdPageWrite(cmdPageWrite), .cmdPageErase(cmdPageErase),
    .cmdPageAddr(cmdPageAddr), .cmdBufFill(cmdBufFill), .cmdBufClear(cmdBufClear),
    .cmdCfgRead(cmdCfgRead), .cmdCfgSel(cmdCfgSel), .readyIrq(readyIrq),
    .fillPending(fillPending)
  );

  // R5
  cfg_needs_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdCfgRead) |-> $past(loadStrobe));
endmodule

// File: tb/sim_flash_prog_ctl.sv
module sim_flash_prog_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic storeStrobe = 1'b0, loadStrobe = 1'b0;
  logic [15:0] zPtr = '0;
  logic eeBusy = 1'b0, flashBusy = 1'b0, globalIntEn = 1'b0;
  logic cmdPageWrite, cmdPageErase, cmdBufFill, cmdBufClear, cmdCfgRead, cmdCfgSel, readyIrq;
  logic [9:0] cmdPageAddr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_prog_ctl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .storeStrobe(storeStrobe), .loadStrobe(loadStrobe),
    .zPtr(zPtr), .eeBusy(eeBusy), .flashBusy(flashBusy), .globalIntEn(globalIntEn),
    .cmdPageWrite(cmdPageWrite), .cmdPageErase(cmdPageErase), .cmdPageAddr(cmdPageAddr),
    .cmdBufFill(cmdBufFill), .cmdBufClear(cmdBufClear), .cmdCfgRead(cmdCfgRead),
    .cmdCfgSel(cmdCfgSel), .readyIrq(readyIrq)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: mode 0 idle, 1 fill, 2 write, 3 erase, 4 cfg, 5 running
  int mode = 0, left = 0, age = 0;
  bit mIe = 0, mBuf = 0;
  bit eWr, eEr, eFill, eCfg, eClr, eSel;
  logic [9:0] eAddr = '0;

  always @(posedge clk) begin
    eWr = 0; eEr = 0; eFill = 0; eCfg = 0; eClr = 0;
    if (!rstN) begin
      mode = 0; left = 0; age = 0; mIe = 0; mBuf = 0; eSel = 0; eAddr = '0;
    end else begin
      int ones;
      ones = 0;
      for (int b = 1; b <= 4; b++) if (regWrData[b]) ones++;
      if (regWrEn) mIe = regWrData[7];
      if (mode == 0) begin
        if (regWrEn && regWrData[0] && ones <= 1) begin
          if (ones == 0)           begin mode = 1; left = 4; end
          else if (regWrData[2])   begin mode = 2; left = 4; end
          else if (regWrData[1])   begin mode = 3; left = 4; end
          else if (regWrData[3])   begin mode = 4; left = 3; end
          else if (mBuf)           begin eClr = 1; mBuf = 0; end
        end
      end else if (mode == 5) begin
        if (age >= 1 && !flashBusy) mode = 0;
        else age++;
      end else begin
        bit hit;
        hit = (mode == 4) ? loadStrobe : storeStrobe;
        if (hit) begin
          case (mode)
            1: begin eFill = 1; mBuf = 1; mode = 0; end
            2: begin eWr = 1; mBuf = 0; eAddr = zPtr[15:6]; mode = 5; age = 0; end
            3: begin eEr = 1; eAddr = zPtr[15:6]; mode = 5; age = 0; end
            default: begin eCfg = 1; eSel = zPtr[0]; mode = 0; end
          endcase
        end else begin
          left--;
          if (left == 0) mode = 0;
        end
      end
    end
  end

  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      logic [7:0] expRd;
      bit expIrq;
      expRd = {mIe, 3'b000, mode == 4, mode == 2, mode == 3, mode != 0};
      expIrq = mIe && globalIntEn && mode == 0 && !eeBusy;
      chk(regRdData == expRd, "R6 readback", {8'h0, regRdData}, {8'h0, expRd});
      chk(readyIrq == expIrq, "R11 irq", {15'h0, readyIrq}, {15'h0, expIrq});
      chk(cmdPageWrite == eWr, "R3 write pulse", {15'h0, cmdPageWrite}, {15'h0, eWr});
      chk(cmdPageErase == eEr, "R4 erase pulse", {15'h0, cmdPageErase}, {15'h0, eEr});
      chk(cmdBufFill == eFill, "R8 fill pulse", {15'h0, cmdBufFill}, {15'h0, eFill});
      chk(cmdBufClear == eClr, "R9 clear pulse", {15'h0, cmdBufClear}, {15'h0, eClr});
      chk(cmdCfgRead == eCfg, "R5 cfg pulse", {15'h0, cmdCfgRead}, {15'h0, eCfg});
      if (eWr || eEr) chk(cmdPageAddr == eAddr, "R3 page addr", {6'h0, cmdPageAddr}, {6'h0, eAddr});
      if (eCfg) chk(cmdCfgSel == eSel, "R5 cfg select", {15'h0, cmdCfgSel}, {15'h0, eSel});
    end
  end

  // flash-busy responder: holds busy for five cycles after each page command
  int busyLeft = 0;
  always @(negedge clk) begin
    if (cmdPageWrite === 1'b1 || cmdPageErase === 1'b1) busyLeft = 5;
    flashBusy <= (busyLeft > 0);
    if (busyLeft > 0) busyLeft--;
  end

  task automatic step(input bit we, input logic [7:0] d, input bit st, input bit ld);
    @(negedge clk);
    regWrEn = we; regWrData = d; storeStrobe = st; loadStrobe = ld;
    @(posedge clk);
    #5;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0);
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 20 && regRdData[0]; i++) idle(1);
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 16'h0, 16'h1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #5;
    // R1 reset state
    chk(regRdData == 8'h00 && !readyIrq && !cmdPageWrite && !cmdCfgRead, "R1 reset",
        {8'h0, regRdData}, 16'h0);

    // R8 fill then R9 clear, then clear on empty buffer
    step(1, 8'h01, 0, 0); idle(2); step(0, 0, 1, 0);
    chk(cmdBufFill == 1'b1, "R8 fill issued", {15'h0, cmdBufFill}, 16'h1);
    step(1, 8'h11, 0, 0);
    chk(cmdBufClear == 1'b1, "R9 clear issued", {15'h0, cmdBufClear}, 16'h1);
    step(1, 8'h11, 0, 0);
    chk(cmdBufClear == 1'b0 && regRdData == 8'h00, "R9 clear on empty", {8'h0, regRdData}, 16'h0);

    // R2 read-only bits
    step(1, 8'h71, 0, 0);
    chk(regRdData[6:4] == 3'b000, "R2 reserved bits", {13'h0, regRdData[6:4]}, 16'h0);

    // R3 page write at the last window edge, R10 busy hold
    zPtr = 16'hABC0;
    step(1, 8'h05, 0, 0);
    chk(regRdData == 8'h05, "R3 armed readback", {8'h0, regRdData}, 16'h5);
    idle(3); step(0, 0, 1, 0);
    chk(cmdPageWrite && cmdPageAddr == 10'h2AF, "R3 last-edge write", {6'h0, cmdPageAddr}, 16'h2AF);
    idle(2);
    chk(regRdData[0] == 1'b1 && flashBusy, "R10 enable held while busy", {8'h0, regRdData}, 16'h1);
    waitIdle();
    chk(regRdData == 8'h00, "R10 enable released", {8'h0, regRdData}, 16'h0);

    // R6 expiry: strobe one edge too late
    step(1, 8'h05, 0, 0); idle(4); step(0, 0, 1, 0);
    chk(!cmdPageWrite && regRdData == 8'h00, "R6 late strobe ignored", {15'h0, cmdPageWrite}, 16'h0);

    // R6 wrong strobe kind
    step(1, 8'h05, 0, 0); step(0, 0, 0, 1);
    chk(!cmdCfgRead && regRdData == 8'h05, "R6 wrong strobe", {8'h0, regRdData}, 16'h5);
    idle(4);

    // R4 erase on first edge
    zPtr = 16'h1240;
    step(1, 8'h03, 0, 0); step(0, 0, 1, 0);
    chk(cmdPageErase && cmdPageAddr == 10'h049, "R4 erase", {6'h0, cmdPageAddr}, 16'h49);
    waitIdle();

    // R5 config reads
    zPtr = 16'h0001;
    step(1, 8'h09, 0, 0); idle(2); step(0, 0, 0, 1);
    chk(cmdCfgRead && cmdCfgSel, "R5 fuse read", {15'h0, cmdCfgSel}, 16'h1);
    zPtr = 16'h0000;
    step(1, 8'h09, 0, 0); step(0, 0, 0, 1);
    chk(cmdCfgRead && !cmdCfgSel, "R5 lock read", {15'h0, cmdCfgSel}, 16'h0);
    step(1, 8'h09, 0, 0); idle(3); step(0, 0, 0, 1);
    chk(!cmdCfgRead, "R6 cfg window expiry", {15'h0, cmdCfgRead}, 16'h0);

    // R7 multiple command bits
    step(1, 8'h07, 0, 0);
    chk(regRdData == 8'h00, "R7 two commands", {8'h0, regRdData}, 16'h0);
    step(1, 8'hFF, 0, 0);
    chk(regRdData == 8'h80, "R7 all bits", {8'h0, regRdData}, 16'h80);

    // R12 write while armed, write without enable
    step(1, 8'h04, 0, 0);
    chk(regRdData == 8'h00, "R12 no enable", {8'h0, regRdData}, 16'h0);
    step(1, 8'h05, 0, 0); step(1, 8'h83, 0, 0);
    chk(regRdData == 8'h85, "R12 armed write", {8'h0, regRdData}, 16'h85);
    idle(4);

    // R11 interrupt gating
    globalIntEn = 1'b1;
    step(1, 8'h80, 0, 0);
    chk(readyIrq == 1'b1, "R11 irq raised", {15'h0, readyIrq}, 16'h1);
    eeBusy = 1'b1; idle(1);
    chk(readyIrq == 1'b0, "R11 eeprom busy", {15'h0, readyIrq}, 16'h0);
    eeBusy = 1'b0;
    step(1, 8'h81, 0, 0);
    chk(readyIrq == 1'b0, "R11 enable set", {15'h0, readyIrq}, 16'h0);
    idle(5);

    // mixed stimulus, compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      zPtr = r[31:16];
      eeBusy = r[12];
      globalIntEn = r[13] | r[14];
      step(r[2:0] == 3'd0, {r[15], r[11:5]}, r[3] & r[4], r[3] & ~r[4]);
    end

    idle(10);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule